// File: doc/BRIEF.md
# Power-Mode Clock Source Controller

This block works out, for each power-managed mode, which oscillators stay powered and which one clocks the core. A three-bit mode code chooses run or idle on the primary, secondary or internal source, or sleep. Two feature flags can keep an oscillator alive whatever the mode. One flag is for the watchdog, which needs the slow internal oscillator. The other is for a timer that counts on the secondary low-frequency oscillator. A four-bit divider select picks the internal clock path. The fast internal clock can be divided by a power of two, or the slow internal clock can drive the core directly.

All outputs come from one register stage. They change only at a rising clock edge, and they show the inputs sampled at the edge before. The oscillators themselves are modelled elsewhere as clock-present signals gated by these enables. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pm_clk_ctrl`

## Requirements
- R1: `pri_en_o` is 1 exactly when the mode is primary run (code 0) or primary idle (code 1). It is 0 in every other mode.
- R2: `sec_en_o` is 1 in secondary run (code 2) and secondary idle (code 3). It is also 1 in any mode, sleep included, while `tmr_sec_en_i` is 1. Otherwise it is 0.
- R3: In an internal mode (run code 4, idle code 5) with `div_sel_i[3]`=0, `ifast_en_o` is 1 and `fast_div_o` equals `div_sel_i[2:0]` (divide by 2^n, where 0 passes the clock through). In every other case `ifast_en_o` and `fast_div_o` are 0.
- R4: In an internal mode with `div_sel_i[3]`=1, the slow internal clock is selected directly: `clk_sel_o`=4, `islow_en_o`=1 and `ifast_en_o`=0.
- R5: `islow_en_o` is 1 whenever `wdt_en_i` is 1, in every mode. Without the watchdog it is 1 only in the case of R4.
- R6: `clk_sel_o` is 1 in primary modes, 2 in secondary modes, 3 for the fast internal path and 4 for the slow internal path. It is 0 (no source) in sleep.
- R7: Run modes give `periph_run_o`=1 and `core_halt_o`=0. Idle modes give `periph_run_o`=1 and `core_halt_o`=1. Sleep gives `periph_run_o`=0 and `core_halt_o`=1.
- R8: Codes 6 and 7 both mean sleep. In sleep the primary and fast internal oscillators are off, and only the oscillators kept alive by R2 or R5 stay enabled.
- R9: Outputs are registered. They show the inputs sampled at the previous rising edge and hold steady between edges. The reset state has every enable at 0, `clk_sel_o`=0, `fast_div_o`=0, `periph_run_o`=0 and `core_halt_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Power mode code |
| wdt_en_i | input | 1 | Watchdog enabled |
| tmr_sec_en_i | input | 1 | Timer needs the secondary oscillator |
| div_sel_i | input | 4 | Internal path select: bit 3 picks slow direct, bits 2:0 give the divide exponent |
| pri_en_o | output | 1 | Primary oscillator enable |
| sec_en_o | output | 1 | Secondary low-frequency oscillator enable |
| ifast_en_o | output | 1 | Fast internal oscillator enable |
| islow_en_o | output | 1 | Slow internal oscillator enable |
| clk_sel_o | output | 3 | Core clock source code |
| fast_div_o | output | 3 | Divide exponent for the fast internal clock |
| periph_run_o | output | 1 | Peripheral clocks running |
| core_halt_o | output | 1 | Core clock halted |

## Verification
The bench targets sleep with the watchdog and the timer flags set. A design that gates every source in sleep would drop the slow or secondary enable there. It covers internal modes with bit 3 of the divider select set; a design that got this wrong would leave the fast oscillator on next to the slow direct path, or report a stale divide exponent. The reserved code 7 is driven to catch a decoder that treats it as a run mode. Outputs are also sampled just after an input change and before the next edge, to catch a combinational path that bypasses the register.

// File: rtl/pm_clk_pkg.sv
package pm_clk_pkg;

  typedef enum logic [2:0] {
    PM_RUN_PRI  = 3'd0,
    PM_IDLE_PRI = 3'd1,
    PM_RUN_SEC  = 3'd2,
    PM_IDLE_SEC = 3'd3,
    PM_RUN_INT  = 3'd4,
    PM_IDLE_INT = 3'd5,
    PM_SLEEP    = 3'd6,
    PM_SLEEP_X  = 3'd7
  } pm_mode_e;

  typedef enum logic [2:0] {
    CSEL_NONE  = 3'd0,
    CSEL_PRI   = 3'd1,
    CSEL_SEC   = 3'd2,
    CSEL_IFAST = 3'd3,
    CSEL_ISLOW = 3'd4
  } clk_sel_e;

  typedef struct packed {
    logic is_pri;
    logic is_sec;
    logic is_int;
    logic is_idle;
    logic is_sleep;
  } mode_dec_t;

endpackage

// File: rtl/pm_mode_decode.sv
module pm_mode_decode
  import pm_clk_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_dec_t  dec_o
);

  always_comb begin
    dec_o = '0;
    unique case (mode_i)
      PM_RUN_PRI:  dec_o.is_pri = 1'b1;
      PM_IDLE_PRI: begin
        dec_o.is_pri  = 1'b1;
        dec_o.is_idle = 1'b1;
      end
      PM_RUN_SEC:  dec_o.is_sec = 1'b1;
      PM_IDLE_SEC: begin
        dec_o.is_sec  = 1'b1;
        dec_o.is_idle = 1'b1;
      end
      PM_RUN_INT:  dec_o.is_int = 1'b1;
      PM_IDLE_INT: begin
        dec_o.is_int  = 1'b1;
        dec_o.is_idle = 1'b1;
      end
      default:     dec_o.is_sleep = 1'b1;
    endcase
  end

endmodule

// File: rtl/pm_osc_enables.sv
module pm_osc_enables
  import pm_clk_pkg::*;
(
  input  mode_dec_t dec_i,
  input  logic      wdt_en_i,
  input  logic      tmr_sec_en_i,
  input  logic      slow_direct_i,
  output logic      pri_en_o,
  output logic      sec_en_o,
  output logic      ifast_en_o,
  output logic      islow_en_o
);

  always_comb begin
    pri_en_o   = dec_i.is_pri;
    sec_en_o   = dec_i.is_sec | tmr_sec_en_i;
    ifast_en_o = dec_i.is_int & ~slow_direct_i;
    islow_en_o = wdt_en_i | (dec_i.is_int & slow_direct_i);
  end

endmodule

// File: rtl/pm_clk_route.sv
module pm_clk_route
  import pm_clk_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  mode_dec_t        dec_i,
  input  logic             slow_direct_i,
  input  logic [DIV_W-1:0] div_exp_i,
  output clk_sel_e         sel_o,
  output logic [DIV_W-1:0] div_o,
  output logic             periph_run_o,
  output logic             core_halt_o
);

  always_comb begin
    sel_o = CSEL_NONE;
    div_o = '0;
    if (dec_i.is_pri) begin
      sel_o = CSEL_PRI;
    end else if (dec_i.is_sec) begin
      sel_o = CSEL_SEC;
    end else if (dec_i.is_int) begin
      if (slow_direct_i) begin
        sel_o = CSEL_ISLOW;
      end else begin
        sel_o = CSEL_IFAST;
        div_o = div_exp_i;
      end
    end
    periph_run_o = ~dec_i.is_sleep;
    core_halt_o  = dec_i.is_idle | dec_i.is_sleep;
  end

endmodule

// File: rtl/pm_clk_ctrl.sv
module pm_clk_ctrl
  import pm_clk_pkg::*;
#(
  parameter int DIV_W  = 3,
  localparam int SEL_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             wdt_en_i,
  input  logic             tmr_sec_en_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             pri_en_o,
  output logic             sec_en_o,
  output logic             ifast_en_o,
  output logic             islow_en_o,
  output logic [2:0]       clk_sel_o,
  output logic [DIV_W-1:0] fast_div_o,
  output logic             periph_run_o,
  output logic             core_halt_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  mode_dec_t        dec;
  logic             slow_direct;
  logic             pri_d, sec_d, ifast_d, islow_d, run_d, halt_d;
  clk_sel_e         sel_d;
  logic [DIV_W-1:0] div_d;

  assign slow_direct = div_sel_i[SEL_W-1];

  pm_mode_decode u_dec (
    .mode_i (mode_i),
    .dec_o  (dec)
  );

  pm_osc_enables u_osc (
    .dec_i         (dec),
    .wdt_en_i      (wdt_en_i),
    .tmr_sec_en_i  (tmr_sec_en_i),
    .slow_direct_i (slow_direct),
    .pri_en_o      (pri_d),
    .sec_en_o      (sec_d),
    .ifast_en_o    (ifast_d),
    .islow_en_o    (islow_d)
  );

  pm_clk_route #(.DIV_W(DIV_W)) u_route (
    .dec_i         (dec),
    .slow_direct_i (slow_direct),
    .div_exp_i     (div_sel_i[DIV_W-1:0]),
    .sel_o         (sel_d),
    .div_o         (div_d),
    .periph_run_o  (run_d),
    .core_halt_o   (halt_d)
  );

  // output register with explicit load enable
  localparam int OUT_W = 6 + 3 + DIV_W;
  logic [OUT_W-1:0] out_d, out_q;
  logic             load_en;

  assign out_d   = {pri_d, sec_d, ifast_d, islow_d, run_d, halt_d, 3'(sel_d), div_d};
  assign load_en = (out_d != out_q);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_q <= {6'b000001, 3'(CSEL_NONE), {DIV_W{1'b0}}};
    end else if (load_en) begin
      out_q <= out_d;
    end
  end

  assign {pri_en_o, sec_en_o, ifast_en_o, islow_en_o, periph_run_o, core_halt_o,
          clk_sel_o, fast_div_o} = out_q;

  AST_PRI_OWN_MODE: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i > 3'd1) |=> !pri_en_o); // R1
  AST_SEC_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    tmr_sec_en_i |=> sec_en_o); // R2
  AST_SLOW_EXCLUDES_FAST: assert property (@(posedge clk) disable iff (!rst_ok)
    (clk_sel_o == 3'(CSEL_ISLOW)) |-> (!ifast_en_o && islow_en_o)); // R4
  AST_WDT_KEEPS_SLOW: assert property (@(posedge clk) disable iff (!rst_ok)
    wdt_en_i |=> islow_en_o); // R5
  AST_SEL_SOURCE_ON: assert property (@(posedge clk) disable iff (!rst_ok)
    ((clk_sel_o == 3'(CSEL_PRI)) |-> pri_en_o) and
    ((clk_sel_o == 3'(CSEL_SEC)) |-> sec_en_o) and
    ((clk_sel_o == 3'(CSEL_IFAST)) |-> ifast_en_o)); // R6
  AST_PERIPH_IMPLIES_STATE: assert property (@(posedge clk) disable iff (!rst_ok)
    !periph_run_o |-> core_halt_o); // R7
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i >= 3'd6) |=> (!pri_en_o && !ifast_en_o && clk_sel_o == 3'(CSEL_NONE))); // R8
  AST_DIV_ONLY_FAST: assert property (@(posedge clk) disable iff (!rst_ok)
    (fast_div_o != '0) |-> (clk_sel_o == 3'(CSEL_IFAST))); // R3

endmodule

// File: tb/pm_clk_ctrl_test.sv
`timescale 1ns/1ps
module pm_clk_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic       wdt, tmr;
  logic [3:0] dsel;
  logic       pri, sec, ifast, islow, prun, halt;
  logic [2:0] csel, fdiv;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk; // 250 MHz

  pm_clk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wdt_en_i(wdt), .tmr_sec_en_i(tmr),
    .div_sel_i(dsel), .pri_en_o(pri), .sec_en_o(sec), .ifast_en_o(ifast),
    .islow_en_o(islow), .clk_sel_o(csel), .fast_div_o(fdiv),
    .periph_run_o(prun), .core_halt_o(halt)
  );

  // expected: {pri,sec,ifast,islow,prun,halt,csel[2:0],fdiv[2:0]}
  function automatic logic [11:0] expect_out(logic [2:0] m, logic w, logic t, logic [3:0] d);
    logic e_pri, e_sec, e_f, e_s, e_r, e_h, in_int;
    logic [2:0] e_c, e_d;
    in_int = (m == 3'd4) || (m == 3'd5);
    e_pri = (m <= 3'd1);
    e_sec = (m == 3'd2) || (m == 3'd3) || t;
    e_f   = in_int && !d[3];
    e_s   = w || (in_int && d[3]);
    e_d   = e_f ? d[2:0] : 3'd0;
    if (m <= 3'd1)       e_c = 3'd1;
    else if (m <= 3'd3)  e_c = 3'd2;
    else if (in_int)     e_c = d[3] ? 3'd4 : 3'd3;
    else                 e_c = 3'd0;
    e_r = (m < 3'd6);
    e_h = (m >= 3'd6) || m[0];
    return {e_pri, e_sec, e_f, e_s, e_r, e_h, e_c, e_d};
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (mode=%0d wdt=%0b tmr=%0b sel=%0h)",
               tag, act, exp, mode, wdt, tmr, dsel);
    end
  endtask

  task automatic check_all(logic [11:0] e);
    chk("R1 pri_en",     {3'b0, pri},   {3'b0, e[11]});
    chk("R2 sec_en",     {3'b0, sec},   {3'b0, e[10]});
    chk("R3 ifast_en",   {3'b0, ifast}, {3'b0, e[9]});
    chk("R3 fast_div",   {1'b0, fdiv},  {1'b0, e[2:0]});
    chk("R5 islow_en",   {3'b0, islow}, {3'b0, e[8]});
    chk("R6 clk_sel",    {1'b0, csel},  {1'b0, e[5:3]});
    chk("R7 run/halt",   {2'b0, prun, halt}, {2'b0, e[7:6]});
  endtask

  task automatic step(logic [2:0] m, logic w, logic t, logic [3:0] d);
    @(negedge clk);
    mode = m; wdt = w; tmr = t; dsel = d;
    @(negedge clk);
    check_all(expect_out(m, w, t, d));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] prev;
    void'($urandom(32'd1234));
    rst_n = 1'b0; mode = 3'd4; wdt = 1'b1; tmr = 1'b1; dsel = 4'h3;
    repeat (3) @(negedge clk);
    // R9 reset state, inputs nonzero during reset
    chk("R9 reset enables", {pri, sec, ifast, islow}, 4'b0000);
    chk("R9 reset sel",     {1'b0, csel}, 4'd0);
    chk("R9 reset div",     {1'b0, fdiv}, 4'd0);
    chk("R9 reset run/halt", {2'b0, prun, halt}, 4'b0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    step(3'd1, 1'b0, 1'b0, 4'h0);   // R1 primary idle keeps primary
    step(3'd6, 1'b1, 1'b1, 4'h0);   // R8 sleep with both features
    chk("R8 sleep gates", {pri, ifast, 2'b0}, 4'b0000);
    step(3'd7, 1'b0, 1'b0, 4'h5);   // R8 reserved code is sleep
    chk("R8 code7 sleep", {1'b0, csel}, 4'd0);
    step(3'd5, 1'b0, 1'b0, 4'h8);   // R4 slow direct, idle
    chk("R4 fast off", {3'b0, ifast}, 4'd0);
    step(3'd4, 1'b0, 1'b0, 4'hF);   // R4 slow direct ignores exponent
    step(3'd4, 1'b0, 1'b0, 4'h7);   // R3 divide by 128
    step(3'd4, 1'b0, 1'b0, 4'h0);   // R3 pass-through
    step(3'd2, 1'b1, 1'b0, 4'h3);   // R2 R5 secondary run with watchdog
    step(3'd0, 1'b0, 1'b1, 4'h8);   // R2 timer keeps secondary in primary run

    // R9 latency: input change is not visible before the next edge
    @(negedge clk);
    prev = expect_out(mode, wdt, tmr, dsel);
    mode = 3'd6; wdt = 1'b0; tmr = 1'b0;
    #1;
    chk("R9 hold pri", {3'b0, pri}, {3'b0, prev[11]});
    chk("R9 hold sel", {1'b0, csel}, {1'b0, prev[5:3]});
    @(negedge clk);
    check_all(expect_out(3'd6, 1'b0, 1'b0, dsel));

    // random mix
    for (int i = 0; i < 400; i++) begin
      step(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 4'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule